// File: doc/BRIEF.md
# Low-Power Stop Mode Controller

This block sequences the stop modes of a small microcontroller. The CPU raises a stop request along with a requested depth: stop1, stop2 or stop3. The controller samples its configuration bits in the cycle it accepts the request. From them it decides which mode is really entered. A deep request (stop1 or stop2) is quietly changed to the shallow stop3 in two cases: debug support is enabled, or low-voltage detection is armed for stop. In either case the regulator is kept fully active rather than dropped to standby.

While stopped, the block gates the peripheral clocks and holds the I/O pin states. It also decides three things from the latched configuration:
- whether the debug clock keeps running,
- whether the real-time interrupt clock keeps running,
- whether the converter goes to its stop state or to power-down.

An enabled interrupt or a low-voltage event returns the block to run. If debug was enabled at entry, a background command instead moves it to an active background state, where debug memory accesses are served. A memory-access-with-status command that arrives while the part is stopped or waiting is not carried out. It is answered with an error flag.

Top module: `stop_mode_ctrl`

## Requirements
- R1: A stop request of depth 1 or 2 accepted while `cfg_dbg_en` is 1 enters stop3 (`mode` = 3). Mode encoding: 0 run, 1 stop1, 2 stop2, 3 stop3, 4 active background.
- R2: A stop request of depth 1 or 2 accepted while both `cfg_lvd_en` and `cfg_lvd_stop_en` are 1 enters stop3. If only one of the two bits is set, the requested depth is kept.
- R3: In any stop mode, `reg_standby` is 0 when debug was enabled or LVD was armed at entry, and 1 otherwise.
- R4: With no override, depth 1, 2 or 3 enters the matching stop mode on the clock edge that samples `stop_req`. Depth 0, a request made in wait, and a request made outside run are all ignored.
- R5: In every stop mode, `periph_clk_en` is 0 and `io_hold` is 1. In run and in active background, `periph_clk_en` is 1 and `io_hold` is 0.
- R6: In stop, `dbg_clk_en` is 1 only if debug was enabled at entry.
- R7: In stop with debug enabled at entry, `bkgd_cmd` moves the block to active background (`mode` = 4) on the next edge. Debug memory commands are then acknowledged. `dbg_go` returns the block to run. If debug was disabled at entry, `bkgd_cmd` has no effect.
- R8: A `mem_cmd` sampled while stopped or while `wait_mode` is 1 gives `mem_err` = 1 and `mem_ack` = 0 on the next cycle. In any other case it gives `mem_ack` = 1 and `mem_err` = 0.
- R9: In stop, the converter is placed in its stop state (`adc_stop` = 1) when the power-up bit was set at entry. Otherwise it is powered down (`adc_pd` = 1). Exactly one of the two is set.
- R10: In stop, `rti_clk_en` follows the RTI enable latched at entry.
- R11: In stop, `irq_wake` or `lvd_event` returns the block to run on the next edge. In that same cycle the clocks are re-enabled and the pin hold is released. An active-low reset also returns it to run.
- R12: Configuration changes made while stopped do not affect the mode outputs until the next entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_req | input | 1 | Stop request from the CPU |
| stop_depth | input | 2 | Requested depth: 1, 2 or 3 |
| wait_mode | input | 1 | CPU is in wait |
| cfg_dbg_en | input | 1 | Debug support enabled |
| cfg_lvd_en | input | 1 | Low-voltage detect enabled |
| cfg_lvd_stop_en | input | 1 | Low-voltage detect kept on in stop |
| cfg_rti_en | input | 1 | RTI kept running in stop |
| cfg_adc_pu | input | 1 | Converter power-up control |
| irq_wake | input | 1 | Enabled interrupt pending |
| lvd_event | input | 1 | Low-voltage event |
| bkgd_cmd | input | 1 | Background command from the debug port |
| dbg_go | input | 1 | Leave active background |
| mem_cmd | input | 1 | Memory-access-with-status command |
| mode | output | 3 | Current mode code |
| reg_standby | output | 1 | Regulator to standby |
| periph_clk_en | output | 1 | Peripheral clock enable |
| dbg_clk_en | output | 1 | Debug logic clock enable |
| io_hold | output | 1 | Hold I/O pin states |
| adc_stop | output | 1 | Converter in stop state |
| adc_pd | output | 1 | Converter powered down |
| rti_clk_en | output | 1 | RTI clock enable |
| mem_err | output | 1 | Memory command refused, part stopped or waiting |
| mem_ack | output | 1 | Memory command performed |

## Verification
The assertions assume that the wake inputs, `bkgd_cmd` and `dbg_go` are single-cycle or level inputs. They also assume that `stop_depth` is stable in the cycle `stop_req` is high. The bench drives every input on the falling edge and keeps each wake or command pulse to one cycle. It holds `stop_req` low while the block is stopped, so each entry is a separate, well-formed request.

// File: rtl/stop_mode_ctrl.sv
module stop_mode_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stop_req,
  input  logic [1:0] stop_depth,
  input  logic       wait_mode,
  input  logic       cfg_dbg_en,
  input  logic       cfg_lvd_en,
  input  logic       cfg_lvd_stop_en,
  input  logic       cfg_rti_en,
  input  logic       cfg_adc_pu,
  input  logic       irq_wake,
  input  logic       lvd_event,
  input  logic       bkgd_cmd,
  input  logic       dbg_go,
  input  logic       mem_cmd,
  output logic [2:0] mode,
  output logic       reg_standby,
  output logic       periph_clk_en,
  output logic       dbg_clk_en,
  output logic       io_hold,
  output logic       adc_stop,
  output logic       adc_pd,
  output logic       rti_clk_en,
  output logic       mem_err,
  output logic       mem_ack
);
  localparam logic [2:0] M_RUN  = 3'd0;
  localparam logic [2:0] M_S1   = 3'd1;
  localparam logic [2:0] M_S2   = 3'd2;
  localparam logic [2:0] M_S3   = 3'd3;
  localparam logic [2:0] M_BKGD = 3'd4;

  logic [2:0] mode_q, entry_mode;
  logic keep_q, dbg_q, rti_q, adcpu_q, stopped, override;

  assign stopped  = (mode_q == M_S1) || (mode_q == M_S2) || (mode_q == M_S3);
  assign override = cfg_dbg_en | (cfg_lvd_en & cfg_lvd_stop_en);

  always_comb begin
    case (stop_depth)
      2'd1:    entry_mode = override ? M_S3 : M_S1;
      2'd2:    entry_mode = override ? M_S3 : M_S2;
      2'd3:    entry_mode = M_S3;
      default: entry_mode = M_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= M_RUN;
      keep_q  <= 1'b0;
      dbg_q   <= 1'b0;
      rti_q   <= 1'b0;
      adcpu_q <= 1'b0;
    end else begin
      case (mode_q)
        M_RUN:
          if (stop_req && !wait_mode && entry_mode != M_RUN) begin
            mode_q  <= entry_mode;
            keep_q  <= override;
            dbg_q   <= cfg_dbg_en;
            rti_q   <= cfg_rti_en;
            adcpu_q <= cfg_adc_pu;
          end
        M_S1, M_S2, M_S3:
          if (bkgd_cmd && dbg_q)           mode_q <= M_BKGD;
          else if (irq_wake || lvd_event)  mode_q <= M_RUN;
        M_BKGD:
          if (dbg_go) mode_q <= M_RUN;
        default: mode_q <= M_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_err <= 1'b0;
      mem_ack <= 1'b0;
    end else begin
      mem_err <= mem_cmd & (stopped | wait_mode);
      mem_ack <= mem_cmd & ~(stopped | wait_mode);
    end
  end

  assign mode          = mode_q;
  assign periph_clk_en = !stopped;
  assign io_hold       = stopped;
  assign reg_standby   = stopped & ~keep_q;
  assign dbg_clk_en    = !stopped || dbg_q;
  assign rti_clk_en    = !stopped || rti_q;
  assign adc_stop      = stopped & adcpu_q;
  assign adc_pd        = stopped & ~adcpu_q;

  AST_DBG_OVERRIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_RUN && stop_req && !wait_mode && cfg_dbg_en && (stop_depth == 2'd1 || stop_depth == 2'd2))
    |=> mode == M_S3); // R1
  AST_LVD_OVERRIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_RUN && stop_req && !wait_mode && cfg_lvd_en && cfg_lvd_stop_en && stop_depth != 2'd0)
    |=> mode == M_S3); // R2
  AST_REG_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(io_hold) && $past(cfg_dbg_en)) |-> !reg_standby && dbg_clk_en); // R3
  AST_CLK_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != M_RUN && mode != M_BKGD) |-> (!periph_clk_en && io_hold)); // R5
  AST_BKGD_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (io_hold && dbg_clk_en && bkgd_cmd && $stable(mode)) |=> mode == M_BKGD); // R7
  AST_MEM_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cmd && (io_hold || wait_mode)) |=> (mem_err && !mem_ack)); // R8
  AST_ADC_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    io_hold |-> $onehot({adc_stop, adc_pd})); // R9
  AST_WAKE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (io_hold && !dbg_clk_en && (irq_wake || lvd_event)) |=> (mode == M_RUN && periph_clk_en && !io_hold)); // R11
endmodule

// File: tb/stop_mode_ctrl_test.sv
module stop_mode_ctrl_test;
  localparam int PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic stop_req = 0, wait_mode = 0;
  logic [1:0] stop_depth = 0;
  logic cfg_dbg_en = 0, cfg_lvd_en = 0, cfg_lvd_stop_en = 0, cfg_rti_en = 0, cfg_adc_pu = 0;
  logic irq_wake = 0, lvd_event = 0, bkgd_cmd = 0, dbg_go = 0, mem_cmd = 0;
  logic [2:0] mode;
  logic reg_standby, periph_clk_en, dbg_clk_en, io_hold, adc_stop, adc_pd, rti_clk_en, mem_err, mem_ack;
  int total = 0, bad = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  stop_mode_ctrl uut (
    .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .stop_depth(stop_depth), .wait_mode(wait_mode),
    .cfg_dbg_en(cfg_dbg_en), .cfg_lvd_en(cfg_lvd_en), .cfg_lvd_stop_en(cfg_lvd_stop_en),
    .cfg_rti_en(cfg_rti_en), .cfg_adc_pu(cfg_adc_pu), .irq_wake(irq_wake), .lvd_event(lvd_event),
    .bkgd_cmd(bkgd_cmd), .dbg_go(dbg_go), .mem_cmd(mem_cmd), .mode(mode), .reg_standby(reg_standby),
    .periph_clk_en(periph_clk_en), .dbg_clk_en(dbg_clk_en), .io_hold(io_hold), .adc_stop(adc_stop),
    .adc_pd(adc_pd), .rti_clk_en(rti_clk_en), .mem_err(mem_err), .mem_ack(mem_ack));

  task automatic chk(input string tag, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic set_cfg(input logic d, input logic l, input logic ls, input logic r, input logic a);
    cfg_dbg_en = d; cfg_lvd_en = l; cfg_lvd_stop_en = ls; cfg_rti_en = r; cfg_adc_pu = a;
  endtask

  task automatic request(input logic [1:0] depth);
    @(negedge clk); stop_req = 1; stop_depth = depth;
    @(negedge clk); stop_req = 0;
  endtask

  task automatic pulse_irq();
    @(negedge clk); irq_wake = 1;
    @(negedge clk); irq_wake = 0;
  endtask

  task automatic mem_probe(output logic e, output logic a);
    @(negedge clk); mem_cmd = 1;
    @(negedge clk); mem_cmd = 0; e = mem_err; a = mem_ack;
  endtask

  task automatic t_reset();
    chk("R5 reset mode", mode, 0);
    chk("R5 reset periph clk", periph_clk_en, 1);
    chk("R5 reset hold", io_hold, 0);
    chk("R8 reset mem_err", mem_err, 0);
  endtask

  task automatic t_plain_stop2();
    set_cfg(0, 0, 0, 0, 0);
    request(2);
    chk("R4 stop2 mode", mode, 2);
    chk("R3 stop2 standby", reg_standby, 1);
    chk("R5 stop2 periph", periph_clk_en, 0);
    chk("R5 stop2 hold", io_hold, 1);
    chk("R6 stop2 dbg clk", dbg_clk_en, 0);
    chk("R9 stop2 adc_pd", adc_pd, 1);
    chk("R9 stop2 adc_stop", adc_stop, 0);
    chk("R10 stop2 rti", rti_clk_en, 0);
    pulse_irq();
    chk("R11 irq wake mode", mode, 0);
    chk("R11 irq wake clk", periph_clk_en, 1);
    chk("R11 irq wake hold", io_hold, 0);
  endtask

  task automatic t_debug_stop1();
    logic e, a;
    set_cfg(1, 0, 0, 0, 0);
    request(1);
    chk("R1 dbg override mode", mode, 3);
    chk("R3 dbg regulator", reg_standby, 0);
    chk("R6 dbg clk runs", dbg_clk_en, 1);
    chk("R5 dbg periph off", periph_clk_en, 0);
    mem_probe(e, a);
    chk("R8 stop mem_err", e, 1);
    chk("R8 stop mem_ack", a, 0);
    @(negedge clk); bkgd_cmd = 1;
    @(negedge clk); bkgd_cmd = 0;
    chk("R7 bkgd mode", mode, 4);
    chk("R7 bkgd periph", periph_clk_en, 1);
    mem_probe(e, a);
    chk("R7 bkgd mem_ack", a, 1);
    chk("R8 bkgd mem_err", e, 0);
    @(negedge clk); dbg_go = 1;
    @(negedge clk); dbg_go = 0;
    chk("R7 go to run", mode, 0);
    set_cfg(0, 0, 0, 0, 0);
  endtask

  task automatic t_lvd();
    set_cfg(0, 1, 0, 0, 0);
    request(2);
    chk("R2 lvd only keeps depth", mode, 2);
    pulse_irq();
    set_cfg(0, 0, 1, 0, 0);
    request(1);
    chk("R2 stop-en only keeps depth", mode, 1);
    pulse_irq();
    set_cfg(0, 1, 1, 0, 0);
    request(2);
    chk("R2 lvd override mode", mode, 3);
    chk("R3 lvd regulator", reg_standby, 0);
    chk("R6 lvd dbg clk off", dbg_clk_en, 0);
    @(negedge clk); lvd_event = 1;
    @(negedge clk); lvd_event = 0;
    chk("R11 lvd wake", mode, 0);
    set_cfg(0, 0, 0, 0, 0);
  endtask

  task automatic t_stop3_latch();
    set_cfg(0, 0, 0, 1, 1);
    request(3);
    chk("R4 stop3 mode", mode, 3);
    chk("R3 stop3 standby", reg_standby, 1);
    chk("R10 rti on", rti_clk_en, 1);
    chk("R9 adc stop", adc_stop, 1);
    chk("R9 adc not pd", adc_pd, 0);
    set_cfg(1, 0, 0, 0, 0);
    @(negedge clk);
    chk("R12 rti latched", rti_clk_en, 1);
    chk("R12 adc latched", adc_stop, 1);
    chk("R12 dbg clk latched", dbg_clk_en, 0);
    @(negedge clk); bkgd_cmd = 1;
    @(negedge clk); bkgd_cmd = 0;
    chk("R7 bkgd ignored", mode, 3);
    pulse_irq();
    chk("R11 wake from stop3", mode, 0);
    set_cfg(0, 0, 0, 0, 0);
  endtask

  task automatic t_ignored();
    logic e, a;
    request(0);
    chk("R4 depth0 ignored", mode, 0);
    @(negedge clk); wait_mode = 1;
    request(2);
    chk("R4 wait request ignored", mode, 0);
    mem_probe(e, a);
    chk("R8 wait mem_err", e, 1);
    chk("R8 wait mem_ack", a, 0);
    @(negedge clk); wait_mode = 0;
    mem_probe(e, a);
    chk("R8 run mem_ack", a, 1);
    request(1);
    chk("R4 stop1 mode", mode, 1);
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    chk("R11 reset wake", mode, 0);
    chk("R11 reset hold", io_hold, 0);
  endtask

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_plain_stop2();
    t_debug_stop1();
    t_lvd();
    t_stop3_latch();
    t_ignored();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule